// File: doc/BRIEF.md
# Fractional UART Baud Tick Generator

This block derives the 16x oversampling tick of a UART from a faster source clock. One UART bit is divided into sixteen sample periods. Each period lasts a whole number of source clocks set by an integer divisor. Any period can be lengthened by one clock through a per-slot stretch mask, which gives the bit rate a fractional resolution of one sixteenth of a clock per sample. Each stretched slot stands on its own, so no fractional remainder builds up.

There are two configuration modes. In mask mode, software supplies the 16-bit stretch mask directly and should spread its set bits across the word. In count mode, software supplies only the number of extra clocks per bit, which is the remainder of clock/baud modulo 16. The block then turns that count into an evenly spread mask. The divisor input holds the whole clocks per sample minus one. The outputs are a one-clock tick at the end of every sample period and a strobe on the tick that closes the sixteenth period. The block loads a new configuration at each bit boundary, and also at every cycle while it is disabled.

Top module: `baud_tick_gen`

## Requirements
- R1: While rst_n is low, tick_o and bit_o stay low, even if en_i is high.
- R2: While en_i is low, no tick or strobe is produced and the slot and clock counters are held at zero. After en_i rises, counting restarts at slot 0, so the first tick comes (div_i+1) clocks later, plus one clock if slot 0 is stretched.
- R3: In mask mode (mode_i=0), sixteen consecutive periods together span 16·(div_i+1) + popcount(mask_i) clocks.
- R4: Sample period k (slot 0 is the first period after a bit boundary) lasts div_i+1 clocks, plus 1 when bit k of the active mask is set. tick_o is high for exactly the last clock of each period.
- R5: bit_o pulses for one clock together with the tick that ends slot 15, and never without a tick. The next period is slot 0.
- R6: In count mode (mode_i=1) with count n = frac_i, slot i is stretched exactly when floor((i+1)·n/16) differs from floor(i·n/16). A bit therefore spans 16·(div_i+1)+n clocks.
- R7: A zero mask in mask mode, or a zero count in count mode, makes every period exactly div_i+1 clocks long.
- R8: If the configuration inputs change while the block is enabled, the bit in progress keeps its old divisor and mask. The new values apply from the next slot 0.
- R9: The field that the selected mode does not use has no effect. frac_i is ignored in mask mode, and mask_i is ignored in count mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Synchronous enable; low holds counters at zero |
| mode_i | input | 1 | 0: stretch mask from mask_i; 1: expand count frac_i |
| div_i | input | DIV_W | Clocks per sample period minus one |
| mask_i | input | 16 | Per-slot stretch mask, bit i for slot i |
| frac_i | input | 4 | Number of stretched slots per bit (count mode) |
| tick_o | output | 1 | One-clock pulse ending each sample period |
| bit_o | output | 1 | One-clock pulse on the tick that ends slot 15 |

## Verification
The assertions take for granted that rst_n is low during the first clock and that every input is known (not X) after reset. The counter bound also relies on the active divisor changing only when the clock counter is at zero, which the configuration register ensures by loading only at bit boundaries or while the block is disabled. The stimulus drives every input to a defined value from time zero and changes configuration only one cycle after a clock edge. Most changes are made while the block is disabled. The single change made during a bit is timed several ticks into that bit, so that the expected deferral to the next slot 0 can be predicted.

// File: rtl/baudfrac_pkg.sv
package baudfrac_pkg;
    // Sample periods per UART bit; must be a power of two so the slot index wraps.
    localparam int SLOTS  = 16;
    localparam int SLOT_W = $clog2(SLOTS);
endpackage

// File: rtl/frac_spread.sv
// Expands a stretch count into a mask whose set bits are evenly spaced.
module frac_spread
    import baudfrac_pkg::*;
(
    input  logic [SLOT_W-1:0] n_i,
    output logic [SLOTS-1:0]  mask_o
);
    localparam int PW = 2 * SLOT_W + 1;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [PW-1:0] lo_p;
        logic [PW-1:0] hi_p;
        assign lo_p = PW'(i * n_i);
        assign hi_p = PW'((i + 1) * n_i);
        assign mask_o[i] = (lo_p >> SLOT_W) != (hi_p >> SLOT_W);
    end

    // R6: the expansion stretches exactly n slots
    always_comb begin
        if (!$isunknown(n_i))
            assert_popcount_R6: assert ($countones(mask_o) == int'(n_i));
    end
endmodule

// File: rtl/slot_seq.sv
// Counts clocks inside a sample period and sample periods inside a bit.
module slot_seq
    import baudfrac_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              stretch_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic              tick_o,
    output logic              bit_o
);
    localparam int CNT_W = DIV_W + 1;
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [SLOT_W-1:0] slot;
    } seq_t;

    seq_t             seq_d, seq_q;
    logic [CNT_W-1:0] limit;
    logic             end_p;

    always_comb begin
        limit  = {1'b0, div_i} + CNT_W'(stretch_i);
        end_p  = en_i && (seq_q.cnt == limit);
        seq_d  = seq_q;
        if (!en_i) begin
            seq_d = '0;
        end else if (end_p) begin
            seq_d.cnt  = '0;
            seq_d.slot = seq_q.slot + 1'b1;
        end else begin
            seq_d.cnt  = seq_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign slot_o = seq_q.slot;
    assign tick_o = end_p;
    assign bit_o  = end_p && (seq_q.slot == LAST_SLOT);

    // R4: the clock count never passes the longest period
    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.cnt <= {1'b0, div_i} + 1'b1);
    // R4: a tick restarts the clock count
    assert_tick_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> seq_q.cnt == '0);
    // R2: disabled means both counters at zero next cycle
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (seq_q.cnt == '0 && seq_q.slot == '0));
    // R5: after the strobe the next period is slot 0
    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_o |=> seq_q.slot == '0);
    // R4: a plain tick advances the slot by one
    assert_slot_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !bit_o) |=> seq_q.slot == $past(seq_q.slot) + 1'b1);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baudfrac_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             mode_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [15:0]      mask_i,
    input  logic [3:0]       frac_i,
    output logic             tick_o,
    output logic             bit_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [SLOTS-1:0] mask;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    logic [SLOTS-1:0]  spread_mask;
    logic [SLOTS-1:0]  sel_mask;
    logic [SLOT_W-1:0] slot;
    logic              run;
    logic              tick_w;
    logic              bit_w;

    frac_spread u_spread (
        .n_i    (frac_i[SLOT_W-1:0]),
        .mask_o (spread_mask)
    );

    assign run = en_i && rst_n;

    always_comb begin
        sel_mask = mode_i ? spread_mask : mask_i[SLOTS-1:0];
        cfg_d    = cfg_q;
        if (!run || bit_w) begin
            cfg_d.div  = div_i;
            cfg_d.mask = sel_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    slot_seq #(.DIV_W(DIV_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (run),
        .div_i     (cfg_q.div),
        .stretch_i (cfg_q.mask[slot]),
        .slot_o    (slot),
        .tick_o    (tick_w),
        .bit_o     (bit_w)
    );

    assign tick_o = tick_w;
    assign bit_o  = bit_w;

    // R8: the active configuration holds inside a running bit
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bit_w) |=> $stable(cfg_q));
    // R5: the strobe never appears without a tick
    assert_bit_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_o |-> tick_o);
    // R2: nothing comes out while disabled
    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && $past(!en_i)) |-> !(tick_o || bit_o));
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          mode = 1'b0;
    logic [DW-1:0] div = '0;
    logic [15:0]   mask = '0;
    logic [3:0]    frac = '0;
    logic          tick_o, bit_o;

    int checks = 0;
    int fails = 0;
    int ticks_seen = 0;
    bit started = 1'b0;

    int    len_q[$];
    bit    isbit_q[$];
    int    sum_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    baud_tick_gen #(.DIV_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .mode_i(mode),
        .div_i(div), .mask_i(mask), .frac_i(frac),
        .tick_o(tick_o), .bit_o(bit_o)
    );

    // evenly spread mask as stated in R6
    function automatic logic [15:0] spread(input int n);
        logic [15:0] m = '0;
        for (int i = 0; i < 16; i++)
            if (((i + 1) * n) / 16 != (i * n) / 16) m[i] = 1'b1;
        return m;
    endfunction

    // driver side: expected periods of one bit
    task automatic push_bit(input int d, input logic [15:0] m, input string tag);
        for (int k = 0; k < 16; k++) begin
            len_q.push_back(d + 1 + int'(m[k]));
            isbit_q.push_back(k == 15);
            sum_q.push_back(16 * (d + 1) + $countones(m));
            tag_q.push_back(tag);
        end
    endtask

    task automatic run_cfg(input int d, input logic md, input logic [15:0] m,
                           input logic [3:0] f, input logic [15:0] expm,
                           input int nbits, input string tag);
        @(posedge clk); #1;
        en = 1'b0; div = DW'(d); mode = md; mask = m; frac = f;
        @(posedge clk); #1;
        for (int b = 0; b < nbits; b++) push_bit(d, expm, tag);
        en = 1'b1;
        wait (len_q.size() == 0);
        @(posedge clk); #1;
        en = 1'b0;
    endtask

    // monitor side: measure each period and compare with the queue head
    int cyc = 0;
    int bsum = 0;
    always @(negedge clk) begin
        if (started) begin
            if (!en) begin
                cyc = 0; bsum = 0;
                if (tick_o || bit_o) begin
                    checks++; fails++;
                    $display("FAIL R2: output while disabled tick=%0b bit=%0b expected 0", tick_o, bit_o);
                end
            end else begin
                cyc++;
                if (tick_o) begin
                    ticks_seen++;
                    if (len_q.size() == 0) begin
                        checks++; fails++;
                        $display("FAIL R4: unexpected tick after %0d clocks, expected none", cyc);
                    end else begin
                        int l, s; bit b; string t;
                        l = len_q.pop_front(); b = isbit_q.pop_front();
                        s = sum_q.pop_front(); t = tag_q.pop_front();
                        checks++;
                        if (cyc != l || bit_o != b) begin
                            fails++;
                            $display("FAIL %s: period %0d clocks bit=%0b, expected %0d bit=%0b", t, cyc, bit_o, l, b);
                        end
                        bsum += cyc;
                        if (b) begin
                            checks++;
                            if (bsum != s) begin
                                fails++;
                                $display("FAIL %s: bit window %0d clocks, expected %0d", t, bsum, s);
                            end
                            bsum = 0;
                        end
                    end
                    cyc = 0;
                end else if (bit_o) begin
                    checks++; fails++;
                    $display("FAIL R5: strobe without tick, got 1 expected 0");
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    logic [15:0] rec [16];
    initial begin
        rec = '{16'h0000, 16'h0080, 16'h0808, 16'h0888, 16'h2222, 16'h4924,
                16'h4a52, 16'h54aa, 16'h5555, 16'hd555, 16'hd5d5, 16'hddd5,
                16'hdddd, 16'hdfdd, 16'hdfdf, 16'hffdf};
        // R1: reset overrides enable
        en = 1'b1;
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (tick_o || bit_o) begin
                fails++;
                $display("FAIL R1: tick=%0b bit=%0b during reset, expected 0 0", tick_o, bit_o);
            end
        end
        @(posedge clk); #1;
        en = 1'b0; rst_n = 1'b1;
        // R2: idle with a configuration loaded
        div = DW'(1); mask = 16'hffff;
        repeat (20) begin
            @(negedge clk);
            checks++;
            if (tick_o || bit_o) begin
                fails++;
                $display("FAIL R2: tick=%0b bit=%0b while idle, expected 0 0", tick_o, bit_o);
            end
        end
        started = 1'b1;
        // R3 R4 R5 R9: every recommended mask, frac_i as junk; R7 via mask 0
        for (int i = 0; i < 16; i++)
            run_cfg(2, 1'b0, rec[i], 4'hf, rec[i], 2, (i == 0) ? "R7" : "R3");
        // divisor zero: one clock periods plus stretches (R4)
        run_cfg(0, 1'b0, 16'h5555, 4'h0, 16'h5555, 1, "R4");
        // R6 R9: count mode with mask_i as junk; R7 via count 0
        for (int n = 0; n < 16; n++)
            run_cfg(3, 1'b1, 16'hffff, 4'(n), spread(n), 1, (n == 0) ? "R7" : "R6");
        // R8: change mid-bit; old bit completes, new applies from slot 0
        @(posedge clk); #1;
        en = 1'b0; mode = 1'b0; div = DW'(1); mask = 16'h0000;
        @(posedge clk); #1;
        push_bit(1, 16'h0000, "R8");
        push_bit(4, 16'h5555, "R8");
        en = 1'b1;
        begin
            int base;
            base = ticks_seen;
            wait (ticks_seen >= base + 5);
        end
        @(posedge clk); #1;
        div = DW'(4); mask = 16'h5555;
        wait (len_q.size() == 0);
        @(posedge clk); #1;
        en = 1'b0;
        repeat (4) @(posedge clk);
        checks++;
        if (len_q.size() != 0) begin
            fails++;
            $display("FAIL R3: %0d periods still expected, expected 0", len_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule